// File: doc/BRIEF.md
# Security-Banked Interrupt Distributor Control Register

This block holds the single 32-bit control word of an interrupt distributor: three group enables, two affinity-routing flags, a security-disable flag and a write-pending flag. Two kinds of agent reach it, secure and non-secure. Each kind has its own write mask and its own read view. The block also models the one-way switch that disables security: a write that sets the security-disable flag clears other flags in the same update. After that the flag stays set until reset.

The register is written through a one-cycle write strobe that carries the agent's security attribute and the data. Reads are combinational: the read data shows the stored word as seen by the agent named on the read-side security input. The raw stored word is also driven out for downstream delivery logic. A one-cycle change pulse tells that logic to re-evaluate after every write. A parameter builds a variant in which security is permanently disabled.

Top module: `secbank_ctl`

## Requirements
- R1: After reset, with the default parameters, the stored word and the secure read view equal 0x00000030: bit 4 (secure routing) and bit 5 (non-secure routing) are set, and everything else is clear.
- R2: While bit 6 (security disable) is set, a write from either agent changes only bit 0 (group 0 enable) and bit 1 (non-secure group 1 enable).
- R3: While bit 6 is clear, a secure write changes only bits 0, 1, 2 (secure group 1 enable) and 6.
- R4: While bit 6 is clear, a non-secure write changes only bit 1.
- R5: While bit 6 is clear, a non-secure read returns the stored word ANDed with 0x80000012, so only bits 31, 4 and 1 are visible.
- R6: A secure read, and any read while bit 6 is set, returns the whole stored word.
- R7: A write that sets bit 6 clears bits 2 and 5 in the same update. After that no write can clear bit 6; only reset can.
- R8: Bit 4 always reads as one, bit 5 reads as one while bit 6 is clear, and bit 31 and all undefined bits always read as zero. Writes do not alter any of these bits.
- R9: The change output is high for exactly the one cycle after each accepted write and low in every other cycle, whether or not the write altered the value.
- R10: With FORCE_NOSEC set, the reset value is 0x00000050 and bit 6 stays set. In that variant only bits 0 and 1 can be written, and bits 2 and 5 stay clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_secure | input | 1 | 1 when the writing agent is secure |
| wr_data | input | REG_W | Write data |
| rd_secure | input | 1 | 1 when the reading agent is secure |
| rd_data | output | REG_W | Agent-filtered view of the stored word |
| ctrl_state | output | REG_W | Raw stored word, for downstream use |
| ctrl_changed | output | 1 | One-cycle pulse in the cycle after a write |

## Verification
The hardest state to reach from the ports is the one after the one-way security disable. The bench must first set bit 6 with a secure write. It must then show that the same write cleared bits 2 and 5, and that later writes of zero from either agent leave bit 6 set. To get there, the stimulus first sets bit 2 with a secure write. It then sets bit 6 with bit 2 still requested in the data, so the forced clear can be seen against a request to keep the bit. Zero writes follow from both agents. A mid-run reset then confirms that bit 6 is cleared only by reset. A second instance built with the forced-disable parameter receives the same stimulus throughout.

// File: rtl/secbank_ctl_pkg.sv
package secbank_ctl_pkg;
  // Bit positions, decoded by the delivery logic downstream
  localparam int BIT_EN_G0    = 0;
  localparam int BIT_EN_G1NS  = 1;
  localparam int BIT_EN_G1S   = 2;
  localparam int BIT_ROUTE_S  = 4;
  localparam int BIT_ROUTE_NS = 5;
  localparam int BIT_NOSEC    = 6;
  localparam int BIT_BUSY     = 31;
endpackage

// File: rtl/secbank_ctl_wmask.sv
module secbank_ctl_wmask
  import secbank_ctl_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             nosec,
  input  logic             wr_secure,
  output logic [REG_W-1:0] wmask
);
  localparam logic [REG_W-1:0] ONE = REG_W'(1);
  localparam logic [REG_W-1:0] M_OPEN = (ONE << BIT_EN_G0) | (ONE << BIT_EN_G1NS);
  localparam logic [REG_W-1:0] M_SEC  = M_OPEN | (ONE << BIT_EN_G1S) | (ONE << BIT_NOSEC);
  localparam logic [REG_W-1:0] M_NS   = ONE << BIT_EN_G1NS;

  always_comb begin
    if (nosec) begin
      wmask = M_OPEN;
    end else if (wr_secure) begin
      wmask = M_SEC;
    end else begin
      wmask = M_NS;
    end
  end
endmodule

// File: rtl/secbank_ctl_view.sv
module secbank_ctl_view
  import secbank_ctl_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic [REG_W-1:0] ctrl,
  input  logic             rd_secure,
  output logic [REG_W-1:0] rd_data
);
  localparam logic [REG_W-1:0] ONE = REG_W'(1);
  localparam logic [REG_W-1:0] NS_SEEN =
    (ONE << BIT_BUSY) | (ONE << BIT_ROUTE_S) | (ONE << BIT_EN_G1NS);

  logic filtered;

  always_comb begin
    filtered = !ctrl[BIT_NOSEC] && !rd_secure;
    rd_data  = filtered ? (ctrl & NS_SEEN) : ctrl;
  end
endmodule

// File: rtl/secbank_ctl_store.sv
module secbank_ctl_store
  import secbank_ctl_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter bit FORCE_NOSEC = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] wmask,
  output logic [REG_W-1:0] ctrl_q,
  output logic             chg_q
);
  localparam logic [REG_W-1:0] ONE = REG_W'(1);
  localparam logic [REG_W-1:0] LEGAL =
    (ONE << BIT_EN_G0) | (ONE << BIT_EN_G1NS) | (ONE << BIT_EN_G1S) |
    (ONE << BIT_ROUTE_S) | (ONE << BIT_ROUTE_NS) | (ONE << BIT_NOSEC);
  localparam logic [REG_W-1:0] RST_SEC   = (ONE << BIT_ROUTE_S) | (ONE << BIT_ROUTE_NS);
  localparam logic [REG_W-1:0] RST_NOSEC = (ONE << BIT_ROUTE_S) | (ONE << BIT_NOSEC);
  localparam logic [REG_W-1:0] RST_VAL   = FORCE_NOSEC ? RST_NOSEC : RST_SEC;

  logic [REG_W-1:0] tie_set;
  logic [REG_W-1:0] tie_clr;
  logic [REG_W-1:0] upd;
  logic [REG_W-1:0] ctrl_d;
  logic             ld_en;

  generate
    if (FORCE_NOSEC) begin : g_tied
      assign tie_set = ONE << BIT_NOSEC;
      assign tie_clr = (ONE << BIT_ROUTE_NS) | (ONE << BIT_EN_G1S);
    end else begin : g_banked
      assign tie_set = '0;
      assign tie_clr = '0;
    end
  endgenerate

  // next-state
  always_comb begin
    ld_en = wr_en;
    upd   = (ctrl_q & ~wmask) | (wr_data & wmask);
    if (wr_data[BIT_NOSEC] && wmask[BIT_NOSEC]) begin
      upd[BIT_EN_G1S]   = 1'b0;
      upd[BIT_ROUTE_NS] = 1'b0;
    end
    upd[BIT_ROUTE_S] = 1'b1;
    upd[BIT_BUSY]    = 1'b0;
    if (!upd[BIT_NOSEC]) begin
      upd[BIT_ROUTE_NS] = 1'b1;
    end
    ctrl_d = ((upd & LEGAL) | tie_set) & ~tie_clr;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= RST_VAL;
    end else if (ld_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q <= 1'b0;
    end else begin
      chg_q <= wr_en;
    end
  end
endmodule

// File: rtl/secbank_ctl.sv
module secbank_ctl
  import secbank_ctl_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter bit FORCE_NOSEC = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_secure,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_secure,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] ctrl_state,
  output logic             ctrl_changed
);
  logic [REG_W-1:0] wmask;
  logic [REG_W-1:0] ctrl_q;
  logic             chg_q;

  secbank_ctl_wmask #(.REG_W(REG_W)) u_wmask (
    .nosec     (ctrl_q[BIT_NOSEC]),
    .wr_secure (wr_secure),
    .wmask     (wmask)
  );

  secbank_ctl_store #(.REG_W(REG_W), .FORCE_NOSEC(FORCE_NOSEC)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wmask   (wmask),
    .ctrl_q  (ctrl_q),
    .chg_q   (chg_q)
  );

  secbank_ctl_view #(.REG_W(REG_W)) u_view (
    .ctrl      (ctrl_q),
    .rd_secure (rd_secure),
    .rd_data   (rd_data)
  );

  assign ctrl_state   = ctrl_q;
  assign ctrl_changed = chg_q;
endmodule

// File: rtl/secbank_ctl_chk.sv
module secbank_ctl_chk
  import secbank_ctl_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter bit FORCE_NOSEC = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_secure,
  input logic             rd_secure,
  input logic [REG_W-1:0] rd_data,
  input logic [REG_W-1:0] ctrl_state,
  input logic             ctrl_changed
);
  localparam logic [REG_W-1:0] ONE = REG_W'(1);
  localparam logic [REG_W-1:0] KEEP_NS  = ~(ONE << BIT_EN_G1NS);
  localparam logic [REG_W-1:0] KEEP_OPEN = ~((ONE << BIT_EN_G0) | (ONE << BIT_EN_G1NS));
  localparam logic [REG_W-1:0] KEEP_SEC = ~((ONE << BIT_EN_G0) | (ONE << BIT_EN_G1NS) |
                                            (ONE << BIT_EN_G1S) | (ONE << BIT_ROUTE_NS) |
                                            (ONE << BIT_NOSEC));
  localparam logic [REG_W-1:0] NS_HIDDEN = ~((ONE << BIT_BUSY) | (ONE << BIT_ROUTE_S) |
                                             (ONE << BIT_EN_G1NS));

  p_ds_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctrl_state[BIT_NOSEC]) |=>
      ((ctrl_state & KEEP_OPEN) == ($past(ctrl_state) & KEEP_OPEN)));

  p_sec_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_secure && !ctrl_state[BIT_NOSEC]) |=>
      ((ctrl_state & KEEP_SEC) == ($past(ctrl_state) & KEEP_SEC)));

  p_ns_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_secure && !ctrl_state[BIT_NOSEC]) |=>
      ((ctrl_state & KEEP_NS) == ($past(ctrl_state) & KEEP_NS)));

  p_ns_view_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_state[BIT_NOSEC] && !rd_secure) |-> ((rd_data & NS_HIDDEN) == '0));

  p_full_view_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_secure || ctrl_state[BIT_NOSEC]) |-> (rd_data == ctrl_state));

  p_ds_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_state[BIT_NOSEC] |=> ctrl_state[BIT_NOSEC]);

  p_ds_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_state[BIT_NOSEC] |-> (!ctrl_state[BIT_EN_G1S] && !ctrl_state[BIT_ROUTE_NS]));

  p_fixed_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_state[BIT_ROUTE_S] && !ctrl_state[BIT_BUSY] &&
    (ctrl_state[BIT_NOSEC] || ctrl_state[BIT_ROUTE_NS]));

  p_pulse_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_changed);

  p_pulse_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!ctrl_changed && $stable(ctrl_state)));

  p_forced_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (FORCE_NOSEC != 1'b0) |-> ctrl_state[BIT_NOSEC]);
endmodule

bind secbank_ctl secbank_ctl_chk #(.REG_W(REG_W), .FORCE_NOSEC(FORCE_NOSEC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_secure    (wr_secure),
  .rd_secure    (rd_secure),
  .rd_data      (rd_data),
  .ctrl_state   (ctrl_state),
  .ctrl_changed (ctrl_changed)
);

// File: tb/secbank_ctl_test.sv
`timescale 1ns/1ps
module secbank_ctl_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_secure = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_secure = 1'b0;
  logic [W-1:0] rd_a, st_a, rd_b, st_b;
  logic         chg_a, chg_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0] rd_a;
    logic [W-1:0] st_a;
    logic [W-1:0] rd_b;
    logic [W-1:0] st_b;
    logic         chg;
    string        tag;
  } item_t;

  item_t exp_q[$];
  logic [W-1:0] m_a, m_b;

  always #2 clk = ~clk;  // 250 MHz

  secbank_ctl #(.REG_W(W), .FORCE_NOSEC(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_secure(wr_secure),
    .wr_data(wr_data), .rd_secure(rd_secure), .rd_data(rd_a),
    .ctrl_state(st_a), .ctrl_changed(chg_a));

  secbank_ctl #(.REG_W(W), .FORCE_NOSEC(1'b1)) uut_ds (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_secure(wr_secure),
    .wr_data(wr_data), .rd_secure(rd_secure), .rd_data(rd_b),
    .ctrl_state(st_b), .ctrl_changed(chg_b));

  // Reference model from the requirements
  function automatic logic [W-1:0] model_wr(logic [W-1:0] st, logic sec, logic [W-1:0] d);
    logic [W-1:0] msk, nv;
    if (st[6])    msk = 32'h0000_0003;   // R2
    else if (sec) msk = 32'h0000_0047;   // R3
    else          msk = 32'h0000_0002;   // R4
    nv = (st & ~msk) | (d & msk);
    if (d[6] && msk[6]) nv = nv & ~32'h0000_0024;  // R7
    nv[4]  = 1'b1;                                 // R8
    nv[31] = 1'b0;
    if (!nv[6]) nv[5] = 1'b1;
    return nv & 32'h0000_0077;
  endfunction

  function automatic logic [W-1:0] model_rd(logic [W-1:0] st, logic sec);
    if (!st[6] && !sec) return st & 32'h8000_0012;  // R5
    return st;                                      // R6
  endfunction

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  // Driver: one access per cycle, pushes the expected result
  task automatic access(logic wr, logic wsec, logic [W-1:0] d, logic rsec, string tag);
    item_t it;
    @(negedge clk);
    wr_en = wr; wr_secure = wsec; wr_data = d; rd_secure = rsec;
    if (wr) begin
      m_a = model_wr(m_a, wsec, d);
      m_b = model_wr(m_b, wsec, d);
    end
    it.rd_a = model_rd(m_a, rsec);
    it.st_a = m_a;
    it.rd_b = model_rd(m_b, rsec);
    it.st_b = m_b;
    it.chg  = wr;
    it.tag  = tag;
    exp_q.push_back(it);
  endtask

  // Monitor: compares after the edge that consumed the access
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        chk(it.tag, "rd_data", rd_a, it.rd_a);
        chk(it.tag, "state", st_a, it.st_a);
        chk(it.tag, "changed", {31'b0, chg_a}, {31'b0, it.chg});
        chk(it.tag, "forced rd_data", rd_b, it.rd_b);
        chk(it.tag, "forced state", st_b, it.st_b);
        chk(it.tag, "forced changed", {31'b0, chg_b}, {31'b0, it.chg});
      end
    end
  end

  task automatic do_reset();
    wait (exp_q.size() == 0);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; wr_secure = 1'b0; wr_data = '0; rd_secure = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_a = 32'h0000_0030;
    m_b = 32'h0000_0050;
    #1;
    chk("R1", "reset state", st_a, 32'h0000_0030);
    chk("R1", "reset secure view", rd_a, 32'h0000_0030);
    chk("R10", "forced reset state", st_b, 32'h0000_0050);
    chk("R9", "reset pulse", {31'b0, chg_a}, 32'h0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    access(1, 0, 32'hFFFF_FFFF, 1, "R4 ns write all ones");
    access(0, 0, '0, 1, "R6 secure read / R9 idle");
    access(0, 0, '0, 0, "R5 ns read");
    access(1, 0, 32'h0000_0000, 0, "R4 ns clear bit1");
    access(1, 1, 32'hFFFF_FFBF, 0, "R3 secure write / R8 fixed bits");
    access(0, 0, '0, 0, "R5 ns read hides bits 0 2");
    access(1, 1, 32'h0000_0005, 1, "R3 secure write");
    access(1, 1, 32'h0000_0045, 1, "R7 set disable clears 2 5");
    access(1, 1, 32'h0000_0000, 1, "R7 disable sticky secure");
    access(1, 0, 32'h0000_0000, 0, "R7 disable sticky ns");
    access(1, 0, 32'h0000_00FF, 0, "R2 ns write after disable");
    access(0, 0, '0, 0, "R6 ns read full after disable");
    access(1, 1, 32'h0000_0004, 1, "R2 secure write bit2 blocked");
    access(1, 1, 32'h0000_0004, 1, "R9 repeated write pulses");
    access(0, 1, '0, 1, "R9 idle after write");
    access(1, 0, 32'hFFFF_FFFF, 1, "R10 forced only bits 0 1");
    do_reset();
    access(0, 0, '0, 0, "R7 reset clears disable");
    for (int i = 0; i < 80; i++) begin
      logic [W-1:0] d;
      d = $urandom;
      if ((i % 17) != 3) d[6] = 1'b0;
      access(($urandom % 3) != 0, $urandom % 2, d, $urandom % 2, "R3 R4 R5 R9 mixed");
    end
    access(0, 0, '0, 1, "R8 final");
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule